// File: doc/BRIEF.md
# Serial Transceiver with Register Control

This block is a full-duplex asynchronous serial transceiver with a small register window. Software uses a plain strobe bus to set it up, queue bytes and collect them. The transmit side has a one-byte holding buffer feeding a shift register. The receive side has a synchronizer, a shift register and a one-byte holding register. Both sides share one oversampling baud generator that divides the clock by an integer.

Each frame has:
- one low start bit;
- eight data bits, least significant bit first;
- an optional parity bit;
- one high stop bit.

The parity type is odd or even. The same setting is used to generate parity and to check it, and it counts the data bits together with the parity bit. The receiver samples each bit in its middle, using 16 oversampling ticks per bit.

The receiver reports two error conditions: a parity mismatch, and a line held low for longer than one whole frame. Both are latched as write-one-to-clear flags. A summary bit shows whether either error is pending. One interrupt output combines the two error flags and the receive-data flag, each through its own mask bit. Software can also force the transmit line low to send a break.

Top module: `uart_regs_core`

Register window (address: contents):
- 0 control:
  - bit0 global enable
  - bit1 transmit enable
  - bit2 receive enable
  - bit3 parity type (1 even, 0 odd)
  - bit4 parity bit present
  - bit5 force break
- 1 flags:
  - bit0 break error (W1C)
  - bit1 parity error (W1C)
  - bit2 receive data valid (RO)
  - bit3 transmit busy (RO)
  - bit4 error summary (RO)
- 2 interrupt mask: bits 0 to 2 line up with flag bits 0 to 2.
- 3 data: a write queues a byte; a read returns the received byte.
- 4 divider: the tick period is DIV+1 clocks, so one bit lasts 16*(DIV+1) clocks.

## Requirements
- R1: After reset the control register, mask, flags and divider read 0, txd is high and irq is low.
- R2: A transmitted frame is a low start bit, then 8 data bits LSB first, then a high stop bit. Each bit lasts 16*(DIV+1) clocks.
- R3: With control bit4 set, a parity bit follows the data. It makes the total count of ones even when control bit3 is 1, and odd when control bit3 is 0.
- R4: A received byte is readable at address 3 and sets flag bit2. A read of address 3 clears flag bit2.
- R5: Flag bit1 sets when a received parity bit does not agree with the selected parity type.
- R6: Flag bit0 sets when rxd stays low for longer than one full frame time. It sets once per low period and not for an ordinary frame of zeros.
- R7: Writing 1 to flag bit0 or bit1 clears that bit, and writing 0 leaves it unchanged. If a new error and a clear fall in the same cycle, the bit ends up set.
- R8: Flag bit4 reads 1 exactly while flag bit0 or bit1 is set.
- R9: Flag bit3 reads 1 while the transmit buffer holds a byte or a frame is being shifted out. While control bit5 drives txd low with nothing queued, flag bit3 reads 0.
- R10: Transmission starts only with control bits 0 and 1 both set, and reception only with control bits 0 and 2 both set. Clearing an enable during a frame lets that frame complete.
- R11: irq is the OR of flag bits 0 to 2, each ANDed with the matching mask bit.
- R12: Flag bits 5 and above read 0. Writes to read-only flag bits are ignored. A data write while the transmit buffer is full is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Register address |
| wrEn | input | 1 | Write strobe |
| wrData | input | BUS_W | Write data |
| rdEn | input | 1 | Read strobe (side effect on the data register) |
| rdData | output | BUS_W | Read data, combinational from addr |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Masked interrupt output |

## Verification
A received parity error and a software clear of the same flag bit can land on the same clock edge. To provoke this, the bench writes a clear to flag bit1 on every cycle while a frame with bad parity arrives, with only the parity mask bit set. The rule that setting wins is judged at irq. It must be high for exactly one sampled cycle: the flag sets despite the concurrent clear, and the next clear removes it. A design where the clear won would never raise irq.

// File: rtl/uart_pkg.sv
package uart_pkg;
  localparam int BYTE_W = 8;

  localparam logic [2:0] ADDR_CTRL = 3'd0;
  localparam logic [2:0] ADDR_FLAG = 3'd1;
  localparam logic [2:0] ADDR_MASK = 3'd2;
  localparam logic [2:0] ADDR_DATA = 3'd3;
  localparam logic [2:0] ADDR_DIV  = 3'd4;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP
  } phaseT;

  typedef struct packed {
    logic globalEn;
    logic txEn;
    logic rxEn;
    logic parityEven;
    logic parityOn;
    logic breakSend;
  } cfgT;

  typedef struct packed {
    logic              txLoad;
    logic [BYTE_W-1:0] txByte;
    logic              rxRead;
  } strobeT;

  typedef struct packed {
    logic              txBusy;
    logic              rxValid;
    logic [BYTE_W-1:0] rxByte;
    logic              parityErrSet;
    logic              breakSet;
  } statT;
endpackage

// File: rtl/uart_datapath.sv
module uart_datapath
  import uart_pkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int OS_RATE = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  cfgT              cfg,
  input  logic [DIV_W-1:0] div,
  input  strobeT           stb,
  input  logic             rxd,
  output logic             txd,
  output statT             stat
);
  localparam int OS_W  = $clog2(OS_RATE);
  localparam int BRK_W = $clog2(OS_RATE * 12) + 1;
  localparam logic [OS_W-1:0] OS_LAST = OS_W'(OS_RATE - 1);
  localparam logic [OS_W-1:0] OS_HALF = OS_W'(OS_RATE / 2 - 1);
  localparam logic [2:0] LAST_BIT = 3'(BYTE_W - 1);

  // baud tick
  logic [DIV_W-1:0] divCnt;
  logic tick;
  assign tick = (divCnt >= div);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     divCnt <= '0;
    else if (tick) divCnt <= '0;
    else           divCnt <= divCnt + 1'b1;
  end

  // transmit
  logic txEnable;
  assign txEnable = cfg.globalEn & cfg.txEn;

  logic              txBufFull;
  logic [BYTE_W-1:0] txBuf;
  logic [BYTE_W-1:0] txSh;
  phaseT             txPh;
  logic [OS_W-1:0]   txOs;
  logic [2:0]        txIdx;
  logic              txBit;
  logic              txPar;
  logic              txTake;

  assign txTake = (txPh == S_IDLE) && txBufFull && txEnable && tick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBufFull <= 1'b0;
      txBuf     <= '0;
      txSh      <= '0;
      txPh      <= S_IDLE;
      txOs      <= '0;
      txIdx     <= '0;
      txBit     <= 1'b1;
      txPar     <= 1'b0;
    end else begin
      if (txTake) begin
        txBufFull <= 1'b0;
      end else if (stb.txLoad && !txBufFull) begin
        txBufFull <= 1'b1;
        txBuf     <= stb.txByte;
      end

      if (txTake) begin
        txSh  <= txBuf;
        txPar <= (^txBuf) ^ ~cfg.parityEven;
        txBit <= 1'b0;
        txOs  <= '0;
        txPh  <= S_START;
      end else if (txPh != S_IDLE && tick) begin
        if (txOs == OS_LAST) begin
          txOs <= '0;
          case (txPh)
            S_START: begin
              txPh  <= S_DATA;
              txIdx <= '0;
              txBit <= txSh[0];
            end
            S_DATA: begin
              if (txIdx == LAST_BIT) begin
                if (cfg.parityOn) begin
                  txPh  <= S_PAR;
                  txBit <= txPar;
                end else begin
                  txPh  <= S_STOP;
                  txBit <= 1'b1;
                end
              end else begin
                txIdx <= txIdx + 1'b1;
                txSh  <= txSh >> 1;
                txBit <= txSh[1];
              end
            end
            S_PAR: begin
              txPh  <= S_STOP;
              txBit <= 1'b1;
            end
            default: begin
              txPh  <= S_IDLE;
              txBit <= 1'b1;
            end
          endcase
        end else begin
          txOs <= txOs + 1'b1;
        end
      end
    end
  end

  assign txd         = cfg.breakSend ? 1'b0 : txBit;
  assign stat.txBusy = txBufFull || (txPh != S_IDLE);

  // receive
  logic rxEnable;
  assign rxEnable = cfg.globalEn & cfg.rxEn;

  logic              rxMeta, rxS;
  phaseT             rxPh;
  logic [OS_W-1:0]   rxOs;
  logic [2:0]        rxIdx;
  logic [BYTE_W-1:0] rxSh;
  logic              rxParBit;
  logic              rxArmed;
  logic              rxValid;
  logic [BYTE_W-1:0] rxByte;
  logic              parErrSetR;
  logic              brkSetR;
  logic [BRK_W-1:0]  brkCnt;
  logic [BRK_W-1:0]  brkLimit;
  logic              rxDoneNow;

  assign brkLimit  = cfg.parityOn ? BRK_W'(OS_RATE * 11 + 1) : BRK_W'(OS_RATE * 10 + 1);
  assign rxDoneNow = (rxPh == S_STOP) && tick && (rxOs == OS_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxS    <= 1'b1;
    end else begin
      rxMeta <= rxd;
      rxS    <= rxMeta;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxPh       <= S_IDLE;
      rxOs       <= '0;
      rxIdx      <= '0;
      rxSh       <= '0;
      rxParBit   <= 1'b0;
      rxArmed    <= 1'b0;
      rxValid    <= 1'b0;
      rxByte     <= '0;
      parErrSetR <= 1'b0;
    end else begin
      parErrSetR <= 1'b0;
      if (stb.rxRead) rxValid <= 1'b0;
      if (rxPh == S_IDLE && rxS) rxArmed <= 1'b1;

      case (rxPh)
        S_IDLE: begin
          if (rxEnable && rxArmed && tick && !rxS) begin
            rxPh    <= S_START;
            rxOs    <= '0;
            rxArmed <= 1'b0;
          end
        end
        S_START: begin
          if (tick) begin
            if (rxOs == OS_HALF) begin
              rxOs <= '0;
              if (!rxS) begin
                rxPh  <= S_DATA;
                rxIdx <= '0;
              end else begin
                rxPh  <= S_IDLE;
              end
            end else begin
              rxOs <= rxOs + 1'b1;
            end
          end
        end
        default: begin
          if (tick) begin
            if (rxOs == OS_LAST) begin
              rxOs <= '0;
              if (rxPh == S_DATA) begin
                rxSh <= {rxS, rxSh[BYTE_W-1:1]};
                if (rxIdx == LAST_BIT) rxPh <= cfg.parityOn ? S_PAR : S_STOP;
                else                   rxIdx <= rxIdx + 1'b1;
              end else if (rxPh == S_PAR) begin
                rxParBit <= rxS;
                rxPh     <= S_STOP;
              end else begin
                rxPh       <= S_IDLE;
                rxValid    <= 1'b1;
                rxByte     <= rxSh;
                parErrSetR <= cfg.parityOn && ((^{rxSh, rxParBit}) == cfg.parityEven);
              end
            end else begin
              rxOs <= rxOs + 1'b1;
            end
          end
        end
      endcase
    end
  end

  // break: line low longer than one frame, counted in ticks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      brkCnt  <= '0;
      brkSetR <= 1'b0;
    end else begin
      brkSetR <= 1'b0;
      if (!rxEnable || rxS) begin
        brkCnt <= '0;
      end else if (tick && brkCnt != brkLimit) begin
        brkCnt <= brkCnt + 1'b1;
        if (brkCnt == brkLimit - 1'b1) brkSetR <= 1'b1;
      end
    end
  end

  assign stat.rxValid      = rxValid;
  assign stat.rxByte       = rxByte;
  assign stat.parityErrSet = parErrSetR;
  assign stat.breakSet     = brkSetR;

  // R12: a held byte is not overwritten until the shifter takes it
  a_r12_full_hold: assert property (@(posedge clk) disable iff (!rstN)
    txBufFull && !txTake |=> txBufFull && $stable(txBuf));

  // R10: no frame starts while a direction is disabled
  a_r10_tx_gated: assert property (@(posedge clk) disable iff (!rstN)
    (txPh == S_IDLE) && !txEnable |=> (txPh == S_IDLE));
  a_r10_rx_gated: assert property (@(posedge clk) disable iff (!rstN)
    (rxPh == S_IDLE) && !rxEnable |=> (rxPh == S_IDLE));

  // R4: a read of the data register clears the valid flag
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    stb.rxRead && !rxDoneNow |=> !rxValid);

  // R6: one break report per low period
  a_r6_break_once: assert property (@(posedge clk) disable iff (!rstN)
    brkSetR |=> !brkSetR);
endmodule

// File: rtl/uart_ctrl.sv
module uart_ctrl
  import uart_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 3,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [BUS_W-1:0]  wrData,
  input  logic              rdEn,
  output logic [BUS_W-1:0]  rdData,
  output cfgT               cfg,
  output logic [DIV_W-1:0]  div,
  output strobeT            stb,
  input  statT              stat,
  output logic              irq
);
  localparam int MASK_W = 3;

  logic [2:0] regSel;
  assign regSel = 3'(addr);

  logic wrCtrl, wrFlag, wrMask, wrDiv;
  assign wrCtrl = wrEn && regSel == ADDR_CTRL;
  assign wrFlag = wrEn && regSel == ADDR_FLAG;
  assign wrMask = wrEn && regSel == ADDR_MASK;
  assign wrDiv  = wrEn && regSel == ADDR_DIV;

  logic [MASK_W-1:0] maskR;
  logic brkErr, parErr, intPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg    <= '0;
      div    <= '0;
      maskR  <= '0;
      brkErr <= 1'b0;
      parErr <= 1'b0;
    end else begin
      if (wrCtrl) begin
        cfg.globalEn   <= wrData[0];
        cfg.txEn       <= wrData[1];
        cfg.rxEn       <= wrData[2];
        cfg.parityEven <= wrData[3];
        cfg.parityOn   <= wrData[4];
        cfg.breakSend  <= wrData[5];
      end
      if (wrDiv)  div   <= wrData[DIV_W-1:0];
      if (wrMask) maskR <= wrData[MASK_W-1:0];

      if (stat.breakSet)           brkErr <= 1'b1;
      else if (wrFlag && wrData[0]) brkErr <= 1'b0;
      if (stat.parityErrSet)       parErr <= 1'b1;
      else if (wrFlag && wrData[1]) parErr <= 1'b0;
    end
  end

  assign intPend = brkErr | parErr;

  assign stb.txLoad = wrEn && regSel == ADDR_DATA;
  assign stb.txByte = wrData[BYTE_W-1:0];
  assign stb.rxRead = rdEn && regSel == ADDR_DATA;

  logic [4:0] flagVec;
  assign flagVec = {intPend, stat.txBusy, stat.rxValid, parErr, brkErr};
  assign irq     = |(flagVec[MASK_W-1:0] & maskR);

  always_comb begin
    rdData = '0;
    case (regSel)
      ADDR_CTRL: rdData = BUS_W'({cfg.breakSend, cfg.parityOn, cfg.parityEven,
                                  cfg.rxEn, cfg.txEn, cfg.globalEn});
      ADDR_FLAG: rdData = BUS_W'(flagVec);
      ADDR_MASK: rdData = BUS_W'(maskR);
      ADDR_DATA: rdData = BUS_W'(stat.rxByte);
      ADDR_DIV:  rdData = BUS_W'(div);
      default:   rdData = '0;
    endcase
  end

  logic unusedWr;
  assign unusedWr = ^wrData[BUS_W-1:DIV_W];

  // R7: a new error wins over a clear in the same cycle
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    stat.parityErrSet |=> parErr);
  // R7: writing 1 clears when no new error arrives
  a_r7_clear: assert property (@(posedge clk) disable iff (!rstN)
    wrFlag && wrData[1] && !stat.parityErrSet |=> !parErr);
  // R7: writing 0 keeps the bit
  a_r7_zero_keeps: assert property (@(posedge clk) disable iff (!rstN)
    wrFlag && !wrData[0] && brkErr |=> brkErr);
  // R8: the summary only drops after a flag write
  a_r8_summary_drop: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intPend) |-> $past(wrFlag));
endmodule

// File: rtl/uart_regs_core.sv
module uart_regs_core
  import uart_pkg::*;
#(
  parameter int BUS_W   = 32,
  parameter int ADDR_W  = 3,
  parameter int DIV_W   = 16,
  parameter int OS_RATE = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [BUS_W-1:0]  wrData,
  input  logic              rdEn,
  output logic [BUS_W-1:0]  rdData,
  input  logic              rxd,
  output logic              txd,
  output logic              irq
);
  cfgT              cfg;
  logic [DIV_W-1:0] div;
  strobeT           stb;
  statT             stat;

  uart_ctrl #(.BUS_W(BUS_W), .ADDR_W(ADDR_W), .DIV_W(DIV_W)) uCtrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .cfg(cfg), .div(div), .stb(stb),
    .stat(stat), .irq(irq)
  );

  uart_datapath #(.DIV_W(DIV_W), .OS_RATE(OS_RATE)) uPath (
    .clk(clk), .rstN(rstN), .cfg(cfg), .div(div), .stb(stb),
    .rxd(rxd), .txd(txd), .stat(stat)
  );
endmodule

// File: tb/tb_uart_regs_core.sv
`timescale 1ns/1ps
module tb_uart_regs_core;
  localparam int BIT_CLK = 32;  // DIV=1 -> 2 clocks per tick, 16 ticks per bit
  localparam logic [31:0] EN = 1, TXE = 2, RXE = 4, EVEN = 8, PARON = 16, BRK = 32;

  logic clk = 1'b0, rstN = 1'b0;
  logic [2:0] addr = '0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic rxd = 1'b1;
  logic txd, irq;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  uart_regs_core dut (.clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .rxd(rxd), .txd(txd), .irq(irq));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rdEn = 1'b1; #1 d = rdData;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic capTx(bit withPar, output logic [7:0] data, output logic par, output logic stopBit);
    @(negedge clk);
    while (txd !== 1'b0) @(negedge clk);
    waitClk(BIT_CLK / 2);
    for (int i = 0; i < 8; i++) begin waitClk(BIT_CLK); data[i] = txd; end
    par = 1'b0;
    if (withPar) begin waitClk(BIT_CLK); par = txd; end
    waitClk(BIT_CLK); stopBit = txd;
  endtask

  task automatic sendRx(logic [7:0] d, bit withPar, logic par);
    @(negedge clk); rxd = 1'b0; waitClk(BIT_CLK - 1);
    for (int i = 0; i < 8; i++) begin rxd = d[i]; waitClk(BIT_CLK); end
    if (withPar) begin rxd = par; waitClk(BIT_CLK); end
    rxd = 1'b1; waitClk(BIT_CLK);
  endtask

  task automatic testReset();
    logic [31:0] v;
    rd(3'd0, v); check("R1 ctrl", v, 0);
    rd(3'd1, v); check("R1 flags", v, 0);
    rd(3'd2, v); check("R1 mask", v, 0);
    rd(3'd4, v); check("R1 div", v, 0);
    check("R1 txd", 32'(txd), 1);
    check("R1 irq", 32'(irq), 0);
  endtask

  task automatic testTxFrame();
    logic [7:0] d; logic p, s; logic [31:0] v;
    wr(3'd4, 1);
    wr(3'd0, EN | TXE);
    fork
      capTx(0, d, p, s);
      begin wr(3'd3, 32'hA5); rd(3'd1, v); check("R9 busy while sending", v[3], 1); end
    join
    check("R2 data", 32'(d), 32'hA5);
    check("R2 stop", 32'(s), 1);
    waitClk(40); rd(3'd1, v); check("R9 idle not busy", v[3], 0);
  endtask

  task automatic testTxParity();
    logic [7:0] d; logic p, s;
    wr(3'd0, EN | TXE | PARON | EVEN);
    fork capTx(1, d, p, s); wr(3'd3, 32'h07); join
    check("R3 even data", 32'(d), 32'h07);
    check("R3 even parity bit", 32'(p), 1);
    wr(3'd0, EN | TXE | PARON);
    fork capTx(1, d, p, s); wr(3'd3, 32'h07); join
    check("R3 odd parity bit", 32'(p), 0);
    check("R3 stop after parity", 32'(s), 1);
  endtask

  task automatic testTxEnable();
    logic [7:0] d; logic p, s; logic [31:0] v;
    wr(3'd0, EN | TXE);
    fork capTx(0, d, p, s); begin wr(3'd3, 32'h3C); waitClk(100); wr(3'd0, EN); end join
    check("R10 tx completes after disable", 32'(d), 32'h3C);
    check("R10 tx stop", 32'(s), 1);
    wr(3'd3, 32'h55);
    wr(3'd3, 32'h66);
    waitClk(400);
    check("R10 txd idle when disabled", 32'(txd), 1);
    rd(3'd1, v); check("R9 busy with queued byte", v[3], 1);
    fork capTx(0, d, p, s); wr(3'd0, EN | TXE); join
    check("R12 first byte kept", 32'(d), 32'h55);
    waitClk(40); rd(3'd1, v); check("R12 second write discarded", v[3], 0);
    wr(3'd0, TXE);
    wr(3'd3, 32'h12);
    waitClk(400);
    check("R10 global enable gates tx", 32'(txd), 1);
    fork capTx(0, d, p, s); wr(3'd0, EN | TXE); join
    check("R10 sends after enable", 32'(d), 32'h12);
    waitClk(40);
  endtask

  task automatic testBreakSend();
    logic [31:0] v;
    wr(3'd0, EN | TXE | BRK);
    waitClk(2);
    check("R9 break drives low", 32'(txd), 0);
    rd(3'd1, v); check("R9 not busy in break", v[3], 0);
    wr(3'd0, EN | TXE);
    check("R9 line released", 32'(txd), 1);
  endtask

  task automatic testRx();
    logic [31:0] v;
    wr(3'd0, EN | RXE | PARON | EVEN);
    sendRx(8'h5A, 1, ^8'h5A);
    waitClk(4);
    rd(3'd1, v); check("R4 valid set, no errors", v[4:0] & 5'h17, 5'h04);
    rd(3'd3, v); check("R4 data", v, 32'h5A);
    rd(3'd1, v); check("R4 read clears valid", v[2], 0);
  endtask

  task automatic testParityErr();
    logic [31:0] v;
    sendRx(8'h5A, 1, ~^8'h5A);
    waitClk(4);
    rd(3'd1, v); check("R5 parity error flag", v[1], 1);
    check("R8 summary set", v[4], 1);
    check("R11 masked off", 32'(irq), 0);
    wr(3'd2, 2); check("R11 parity mask", 32'(irq), 1);
    wr(3'd2, 1); check("R11 break mask only", 32'(irq), 0);
    wr(3'd2, 0);
    wr(3'd1, 0);
    rd(3'd1, v); check("R7 write zero keeps", v[1], 1);
    wr(3'd1, 32'hFFFF_FFFC);
    rd(3'd1, v);
    check("R12 reserved read zero", v >> 5, 0);
    check("R12 read-only valid kept", v[2], 1);
    check("R7 bit1 kept on other bits", v[1], 1);
    wr(3'd1, 2);
    rd(3'd1, v); check("R7 write one clears", v[1], 0);
    check("R8 summary clears", v[4], 0);
    rd(3'd3, v);
  endtask

  task automatic testRxEnable();
    logic [31:0] v;
    wr(3'd0, EN | RXE);
    fork sendRx(8'h81, 0, 0); begin waitClk(100); wr(3'd0, EN); end join
    waitClk(4);
    rd(3'd1, v); check("R10 rx completes after disable", v[2], 1);
    rd(3'd3, v); check("R10 rx data", v, 32'h81);
    sendRx(8'h42, 0, 0);
    waitClk(4);
    rd(3'd1, v); check("R10 rx ignored when disabled", v[2], 0);
  endtask

  task automatic testBreakDetect();
    logic [31:0] v;
    wr(3'd0, EN | RXE | PARON | EVEN);
    sendRx(8'h00, 1, 0);
    waitClk(4);
    rd(3'd1, v); check("R6 zero frame is not break", v[1:0], 0);
    rd(3'd3, v);
    @(negedge clk); rxd = 1'b0;
    waitClk(450);
    rd(3'd1, v); check("R6 break detected", v[0], 1);
    rxd = 1'b1;
    waitClk(40);
    wr(3'd1, 1);
    waitClk(40);
    rd(3'd1, v); check("R6 single report per low", v[0], 0);
    rd(3'd3, v);
  endtask

  task automatic testSetWins();
    logic [31:0] v; int hi = 0;
    wr(3'd2, 2);
    fork
      sendRx(8'h33, 1, ~^8'h33);
      begin
        @(negedge clk); addr = 3'd1; wrData = 2; wrEn = 1'b1;
        repeat (11 * BIT_CLK + 8) begin @(negedge clk); if (irq) hi++; end
        wrEn = 1'b0;
      end
    join
    check("R7 set beats same-cycle clear", 32'(hi), 1);
    rd(3'd1, v); check("R7 cleared afterwards", v[1], 0);
    wr(3'd2, 0);
    rd(3'd3, v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    waitClk(3);
    rstN = 1'b1;
    waitClk(2);
    testReset();
    testTxFrame();
    testTxParity();
    testTxEnable();
    testBreakSend();
    testRx();
    testParityErr();
    testRxEnable();
    testBreakDetect();
    wr(3'd0, EN | RXE | PARON | EVEN);
    testSetWins();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule